// File: doc/BRIEF.md
# Iterative Multiple-of-Three Detector

This block decides whether an unsigned operand is a multiple of three by taking three away from a working register, one step per clock, until less than three is left. While the `start` request is low, the working register follows the `operand` input on every clock edge. The working register is always visible on `remainder`.

Raising `start` freezes the loaded value and runs the loop. When it ends, `done` goes high. `is_mult3` goes high with it when nothing is left. Both flags and the remainder hold for as long as `start` stays high. Dropping `start` at any point sends the controller back to idle and resumes loading.

The reset is asynchronous and active low. It clears the flags and the working register.

Top module: `div3_iter`

## Requirements
- R1: While `rst_n` is low, `done`, `is_mult3` and `remainder` are 0 at once, without waiting for a clock edge. After reset the controller sits idle.
- R2: On every rising edge where `start` is low, the working register takes `operand`. Both flags are 0 after that edge.
- R3: With `start` high, the first edge only leaves idle. Each later edge that sees a value of 3 or more lowers `remainder` by exactly 3. Changes on `operand` while `start` is high have no effect.
- R4: The first edge that sees a value below 3 raises `done`. Counting from the first edge with `start` high, `done` is high after floor(A/3)+2 edges.
- R5: When `done` is high, `remainder` equals A mod 3. `is_mult3` is 1 exactly when that remainder is 0, and it is never 1 without `done`.
- R6: While `start` stays high after completion, `done`, `is_mult3` and `remainder` do not change.
- R7: Lowering `start` in any state returns the controller to idle on the next edge. That edge clears both flags and loads `operand`. This also holds when the lowering meets the edge that would have completed the loop.
- R8: Operands 0, 1 and 2 complete without any subtraction. Operand 0 reports `is_mult3` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | High: run and hold the result. Low: idle and load the operand |
| operand | input | W (8) | Value to test |
| remainder | output | W (8) | Current working value |
| done | output | 1 | Loop finished, result held |
| is_mult3 | output | 1 | Operand divisible by three; valid with `done` |

## Verification
Completion of the loop and the withdrawal of `start` can fall on the same clock edge. Withdrawal must win: no flag appears and the operand is loaded again. The bench provokes this by lowering `start` in the cycle before the edge that would raise `done`. A behavioural model that runs alongside judges the outcome on every clock, and directed checks confirm it at the ports. A full sweep of all operands also cross-checks the remainder, the divisibility flag and the latency.

// File: rtl/div3_iter.sv
module div3_iter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] operand,
  output logic [W-1:0] remainder,
  output logic         done,
  output logic         is_mult3
);

  localparam logic [W-1:0] STEP = W'(3);

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_RUN = 2'd1, S_HOLD = 2'd2} state_t;

  state_t      st;
  logic [W-1:0] work;
  logic         below;

  assign below     = work < STEP;
  assign remainder = work;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      work     <= '0;
      done     <= 1'b0;
      is_mult3 <= 1'b0;
    end else if (!start) begin
      st       <= S_IDLE;
      work     <= operand;
      done     <= 1'b0;
      is_mult3 <= 1'b0;
    end else begin
      unique case (st)
        S_IDLE: st <= S_RUN;
        S_RUN: begin
          if (below) begin
            st       <= S_HOLD;
            done     <= 1'b1;
            is_mult3 <= (work == '0);
          end else begin
            work <= work - STEP;
          end
        end
        S_HOLD: st <= S_HOLD;
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

module div3_iter_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [W-1:0] operand,
  input logic [W-1:0] remainder,
  input logic         done,
  input logic         is_mult3,
  input logic [1:0]   st
);

  localparam logic [1:0] C_RUN = 2'd1;

  AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (!done && !is_mult3 && remainder == '0)); // R1

  AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> (remainder == $past(operand) && !done && !is_mult3)); // R2

  AST_STEP_THREE: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RUN && start && remainder >= W'(3)) |=> (remainder == $past(remainder) - W'(3))); // R3

  AST_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (st == C_RUN && start && remainder < W'(3)) |=> (done && is_mult3 == ($past(remainder) == '0))); // R4

  AST_FLAG_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    is_mult3 |-> (done && remainder == '0)); // R5

  AST_DONE_SMALL: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> remainder < W'(3)); // R5

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (done && $stable(remainder) && $stable(is_mult3))); // R6

endmodule

bind div3_iter div3_iter_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
  .remainder(remainder), .done(done), .is_mult3(is_mult3), .st(st)
);

// File: tb/div3_iter_tb.sv
module div3_iter_tb;
  localparam int CLK_PERIOD = 10;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] operand = '0;
  logic [W-1:0] remainder;
  logic         done, is_mult3;

  int tests = 0;
  int fails = 0;
  int cycles = 0;

  int m_st = 0, m_w = 0, m_d = 0, m_v = 0;

  div3_iter #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .operand(operand),
    .remainder(remainder), .done(done), .is_mult3(is_mult3)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  // behavioural reference, updated on the same edges
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_w = 0; m_d = 0; m_v = 0;
    end else if (!start) begin
      m_st = 0; m_w = int'(operand); m_d = 0; m_v = 0;
    end else if (m_st == 0) begin
      m_st = 1;
    end else if (m_st == 1) begin
      if (m_w < 3) begin m_st = 2; m_d = 1; m_v = (m_w == 0); end
      else m_w = m_w - 3;
    end
  end

  always @(negedge clk) begin
    cycles++;
    check(int'(remainder) == m_w, "model remainder (R3)", int'(remainder), m_w);
    check(int'(done) == m_d, "model done (R4)", int'(done), m_d);
    check(int'(is_mult3) == m_v, "model is_mult3 (R5)", int'(is_mult3), m_v);
    if (cycles > 150000) begin
      check(1'b0, "watchdog", cycles, 150000);
      finish_run();
    end
  end

  task automatic run_one(input int a);
    int cnt;
    @(negedge clk); start = 1'b0; operand = W'(a);
    @(negedge clk);
    check(int'(remainder) == a && !done, "R2 load", int'(remainder), a);
    start = 1'b1; operand = ~W'(a);
    cnt = 0;
    while (!done && cnt < 200) begin @(negedge clk); cnt++; end
    check(cnt == a/3 + 2, "R4 latency", cnt, a/3 + 2);
    check(int'(remainder) == a % 3, "R5 remainder", int'(remainder), a % 3);
    check(int'(is_mult3) == int'(a % 3 == 0), "R5 flag", int'(is_mult3), int'(a % 3 == 0));
    if (a < 3) check(cnt == 2, "R8 no subtraction", cnt, 2);
    operand = W'(a + 1);
    repeat (2) @(negedge clk);
    check(done && int'(remainder) == a % 3, "R6 hold", int'(remainder), a % 3);
    start = 1'b0; operand = W'(a ^ 8'h5a);
    @(negedge clk);
    check(!done && !is_mult3 && remainder == W'(a ^ 8'h5a), "R7 release", int'(remainder), a ^ 8'h5a);
  endtask

  initial begin
    #(CLK_PERIOD*2 + 1);
    check(!done && !is_mult3 && remainder == '0, "R1 reset", int'(remainder), 0);
    @(negedge clk); rst_n = 1'b1;

    run_one(0);
    check(1'b1, "R8 zero", 0, 0);
    for (int a = 0; a < 256; a++) run_one(a);

    // abort mid-run
    @(negedge clk); start = 1'b0; operand = 8'd200;
    @(negedge clk); start = 1'b1;
    repeat (5) @(negedge clk);
    check(!done && int'(remainder) == 200 - 12, "R3 progress", int'(remainder), 188);
    start = 1'b0; operand = 8'd33;
    @(negedge clk);
    check(!done && int'(remainder) == 33, "R7 abort", int'(remainder), 33);

    // start drops on the edge that would complete
    operand = 8'd7;
    @(negedge clk); start = 1'b1;
    repeat (3) @(negedge clk);
    check(!done && int'(remainder) == 1, "R3 before collision", int'(remainder), 1);
    start = 1'b0; operand = 8'd9;
    @(negedge clk);
    check(!done && !is_mult3 && int'(remainder) == 9, "R7 collision", int'(remainder), 9);

    // asynchronous reset during hold
    @(negedge clk); start = 1'b1;
    repeat (6) @(negedge clk);
    check(done && is_mult3, "R5 nine", int'(is_mult3), 1);
    #(CLK_PERIOD/4) rst_n = 1'b0;
    #1;
    check(!done && !is_mult3 && remainder == '0, "R1 async", int'(remainder), 0);
    @(negedge clk); start = 1'b0; rst_n = 1'b1;
    @(negedge clk);
    finish_run();
  end
endmodule